// File: doc/BRIEF.md
# Boundary-Scan Test Port with Whole-Bus Drive Control

This block is a serial test access port, clocked by its own test clock, that sits in front of a device's parallel output bus. A 16-state controller, stepped by the mode-select input on rising test-clock edges, runs an instruction register and a boundary register. The boundary register holds one cell per bus bit plus one extra cell. That extra cell is the only tri-state control in the chain, and it decides for the entire bus whether the drivers are on or the bus floats.

In normal operation the functional data and enable pass straight through to the bus. A tester can load the preload-and-sample instruction to snapshot the functional bus and preload the update stage. It can then load the external-test instruction, and from that point the update stage drives the bus pins and its control cell enables or floats the whole bus. Any instruction code without a meaning selects the one-bit bypass path and has no effect on the bus.

The controller states are: Reset, Idle, DR-Select, DR-Capture, DR-Shift, DR-Exit1, DR-Pause, DR-Exit2, DR-Update, IR-Select, IR-Capture, IR-Shift, IR-Exit1, IR-Pause, IR-Exit2 and IR-Update. With tms=1 the transitions are: Reset stays in Reset, Idle goes to DR-Select, DR-Select to IR-Select, IR-Select to Reset, both Capture states and both Shift states go to their Exit1, both Pause states go to their Exit2, both Exit states and both Update states go to DR-Select (the Exit states through their Update). With tms=0 the transitions are: Reset goes to Idle, Idle stays in Idle, the Select states go to their Capture, Capture and Shift go to Shift, Exit1 goes to Pause, Pause stays in Pause, Exit2 goes back to Shift, and Update goes to Idle.

Top module: `bscan_bus_ctl`

## Requirements
- R1: The controller follows the 16-state graph given above. tms is sampled on the rising edge of tck.
- R2: Five consecutive rising edges with tms=1 bring the controller to Reset from any state. trst_n low forces Reset asynchronously.
- R3: The instruction register is IR_W bits wide and shifts toward tdo, least significant bit first, in IR-Shift. IR-Capture loads the value 1 (bit 0 set, all other bits clear). The new instruction takes effect at the edge that leaves IR-Update. Reset loads all ones (bypass).
- R4: Code all-zeros is external test, code 1 is sample/preload, and code all-ones is bypass. Every other code behaves as bypass and never gives the update stage control of the bus.
- R5: The boundary register has BUS_W+1 cells. Cell 0 is nearest tdo, cells 0 to BUS_W-1 hold bus bits 0 to BUS_W-1, and cell BUS_W is the bus control cell. DR-Capture loads {func_oe, func_data}, and DR-Shift moves tdi into cell BUS_W while the other cells move one place toward cell 0.
- R6: The update stage loads the shift cells at the edge that leaves DR-Update, and only while the external-test or sample/preload instruction is current. Otherwise it holds its value.
- R7: Under external test, bus_data equals the data update cells, and bus_oe equals the control update cell (1 drives the bus, 0 floats the whole bus).
- R8: Under any instruction other than external test, bus_data equals func_data and bus_oe equals func_oe.
- R9: The control update cell is set to 1 and the data update cells are cleared on trst_n and on every rising edge in Reset.
- R10: When bypass is selected, the data path is a single cell that captures 0 in DR-Capture and takes tdi in DR-Shift.
- R11: tdo and tdo_oe change only on the falling edge of tck. tdo_oe is 1 only in IR-Shift and DR-Shift. Outside those states tdo is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, steps the controller |
| tdi | input | 1 | Serial data into the selected register |
| func_data | input | BUS_W | Functional output data from the core |
| func_oe | input | 1 | Functional output enable from the core |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_oe | output | 1 | Drive enable for tdo |
| bus_data | output | BUS_W | Value presented to the bus pins |
| bus_oe | output | 1 | Enable of the whole bus driver |

## Verification
A new instruction changes the bus outputs at the rising edge that leaves IR-Update, and a new update-stage value changes them at the rising edge that leaves DR-Update. Both arrive through one register and are then combinational. tdo carries the bit of the current shift state half a cycle after the rising edge that entered it. The bench drives tms and tdi one nanosecond after each falling edge and reads tdo at that same moment, so each read shows the bit of the state entered at the preceding rising edge. Bus outputs are read only once the controller has come back to Idle, at least one full edge after the update that set them.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [3:0] {
        TS_RESET,
        TS_IDLE,
        TS_DR_SEL,
        TS_DR_CAP,
        TS_DR_SHIFT,
        TS_DR_EXIT1,
        TS_DR_PAUSE,
        TS_DR_EXIT2,
        TS_DR_UPD,
        TS_IR_SEL,
        TS_IR_CAP,
        TS_IR_SHIFT,
        TS_IR_EXIT1,
        TS_IR_PAUSE,
        TS_IR_EXIT2,
        TS_IR_UPD
    } tap_state_t;

    typedef enum logic [1:0] {
        INS_BYPASS,
        INS_SAMPLE,
        INS_EXTEST
    } ins_kind_t;

endpackage

// File: rtl/bscan_tap_fsm.sv
module bscan_tap_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output logic       dr_cap,
    output logic       dr_shift,
    output logic       dr_upd,
    output logic       ir_cap,
    output logic       ir_shift,
    output logic       ir_upd
);

    tap_state_t nxt;

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state <= TS_RESET;
        end else begin
            state <= nxt;
        end
    end

    // transition graph
    always_comb begin
        nxt = state;
        unique case (state)
            TS_RESET:    nxt = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     nxt = tms ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   nxt = tms ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   nxt = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_SHIFT: nxt = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_EXIT1: nxt = tms ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: nxt = tms ? TS_DR_EXIT2 : TS_DR_PAUSE;
            TS_DR_EXIT2: nxt = tms ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   nxt = tms ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   nxt = tms ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   nxt = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_SHIFT: nxt = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_EXIT1: nxt = tms ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: nxt = tms ? TS_IR_EXIT2 : TS_IR_PAUSE;
            TS_IR_EXIT2: nxt = tms ? TS_IR_UPD   : TS_IR_SHIFT;
            TS_IR_UPD:   nxt = tms ? TS_DR_SEL   : TS_IDLE;
            default:     nxt = TS_RESET;
        endcase
    end

    // state decodes
    always_comb begin
        in_reset = 1'b0;
        dr_cap   = 1'b0;
        dr_shift = 1'b0;
        dr_upd   = 1'b0;
        ir_cap   = 1'b0;
        ir_shift = 1'b0;
        ir_upd   = 1'b0;
        unique case (state)
            TS_RESET:    in_reset = 1'b1;
            TS_DR_CAP:   dr_cap   = 1'b1;
            TS_DR_SHIFT: dr_shift = 1'b1;
            TS_DR_UPD:   dr_upd   = 1'b1;
            TS_IR_CAP:   ir_cap   = 1'b1;
            TS_IR_SHIFT: ir_shift = 1'b1;
            TS_IR_UPD:   ir_upd   = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/bscan_instr_reg.sv
module bscan_instr_reg #(
    parameter int IR_W = 3
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            cap,
    input  logic            shift,
    input  logic            upd,
    input  logic            tlr,
    output logic [IR_W-1:0] ir_cur,
    output logic            so
);

    localparam logic [IR_W-1:0] CAP_PAT   = IR_W'(1);
    localparam logic [IR_W-1:0] OP_BYPASS = '1;

    logic [IR_W-1:0] sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr <= CAP_PAT;
        end else if (cap) begin
            sr <= CAP_PAT;
        end else if (shift) begin
            sr <= {tdi, sr[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_cur <= OP_BYPASS;
        end else if (tlr) begin
            ir_cur <= OP_BYPASS;
        end else if (upd) begin
            ir_cur <= sr;
        end
    end

    assign so = sr[0];

endmodule

// File: rtl/bscan_bound_reg.sv
module bscan_bound_reg #(
    parameter int BUS_W = 8
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  logic             cap,
    input  logic             shift,
    input  logic             upd,
    input  logic             tlr,
    input  logic             sel,
    input  logic [BUS_W-1:0] func_data,
    input  logic             func_oe,
    output logic [BUS_W-1:0] upd_data,
    output logic             upd_oe,
    output logic             so
);

    localparam int LEN = BUS_W + 1;
    localparam int CTL = BUS_W;
    localparam logic [LEN-1:0] UPD_INIT = {1'b1, {BUS_W{1'b0}}};

    logic [LEN-1:0] sr;
    logic [LEN-1:0] sr_nxt;
    logic [LEN-1:0] upd_q;

    generate
        for (genvar i = 0; i < LEN; i++) begin : g_cell
            logic cap_v;
            logic shin;
            if (i == CTL) begin : g_ctl
                assign cap_v = func_oe;
                assign shin  = tdi;
            end else begin : g_dat
                assign cap_v = func_data[i];
                assign shin  = sr[i+1];
            end
            assign sr_nxt[i] = (sel && cap)   ? cap_v :
                               (sel && shift) ? shin  : sr[i];
        end
    endgenerate

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr <= '0;
        end else begin
            sr <= sr_nxt;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            upd_q <= UPD_INIT;
        end else if (tlr) begin
            upd_q <= UPD_INIT;
        end else if (sel && upd) begin
            upd_q <= sr;
        end
    end

    assign upd_data = upd_q[BUS_W-1:0];
    assign upd_oe   = upd_q[CTL];
    assign so       = sr[0];

endmodule

// File: rtl/bscan_bus_ctl.sv
module bscan_bus_ctl
    import bscan_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int IR_W  = 3
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BUS_W-1:0] func_data,
    input  logic             func_oe,
    output logic             tdo,
    output logic             tdo_oe,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_oe
);

    localparam logic [IR_W-1:0] OP_EXTEST = '0;
    localparam logic [IR_W-1:0] OP_SAMPLE = IR_W'(1);

    tap_state_t      tap_state;
    logic            in_reset;
    logic            dr_cap;
    logic            dr_shift;
    logic            dr_upd;
    logic            ir_cap;
    logic            ir_shift;
    logic            ir_upd;
    logic [IR_W-1:0] ir_cur;
    logic            ir_so;
    ins_kind_t       kind;
    logic            sel_bound;
    logic            extest;
    logic [BUS_W-1:0] upd_data;
    logic            upd_oe;
    logic            bnd_so;
    logic            byp_q;

    bscan_tap_fsm u_fsm (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .state    (tap_state),
        .in_reset (in_reset),
        .dr_cap   (dr_cap),
        .dr_shift (dr_shift),
        .dr_upd   (dr_upd),
        .ir_cap   (ir_cap),
        .ir_shift (ir_shift),
        .ir_upd   (ir_upd)
    );

    bscan_instr_reg #(.IR_W(IR_W)) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .cap    (ir_cap),
        .shift  (ir_shift),
        .upd    (ir_upd),
        .tlr    (in_reset),
        .ir_cur (ir_cur),
        .so     (ir_so)
    );

    // instruction decode; unknown codes fall to bypass
    always_comb begin
        if (ir_cur == OP_EXTEST) begin
            kind = INS_EXTEST;
        end else if (ir_cur == OP_SAMPLE) begin
            kind = INS_SAMPLE;
        end else begin
            kind = INS_BYPASS;
        end
    end

    assign sel_bound = (kind != INS_BYPASS);
    assign extest    = (kind == INS_EXTEST);

    bscan_bound_reg #(.BUS_W(BUS_W)) u_bnd (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .cap       (dr_cap),
        .shift     (dr_shift),
        .upd       (dr_upd),
        .tlr       (in_reset),
        .sel       (sel_bound),
        .func_data (func_data),
        .func_oe   (func_oe),
        .upd_data  (upd_data),
        .upd_oe    (upd_oe),
        .so        (bnd_so)
    );

    // single-cell bypass path
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (!sel_bound && dr_cap) begin
            byp_q <= 1'b0;
        end else if (!sel_bound && dr_shift) begin
            byp_q <= tdi;
        end
    end

    // serial out, retimed to the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            unique case (tap_state)
                TS_IR_SHIFT: begin
                    tdo    <= ir_so;
                    tdo_oe <= 1'b1;
                end
                TS_DR_SHIFT: begin
                    tdo    <= sel_bound ? bnd_so : byp_q;
                    tdo_oe <= 1'b1;
                end
                default: begin
                    tdo    <= 1'b0;
                    tdo_oe <= 1'b0;
                end
            endcase
        end
    end

    // bus output selection
    always_comb begin
        if (extest) begin
            bus_data = upd_data;
            bus_oe   = upd_oe;
        end else begin
            bus_data = func_data;
            bus_oe   = func_oe;
        end
    end

endmodule

// File: rtl/bscan_bus_ctl_chk.sv
module bscan_bus_ctl_chk
    import bscan_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int IR_W  = 3
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tms,
    input tap_state_t       tap_state,
    input logic [IR_W-1:0]  ir_cur,
    input logic             upd_oe,
    input logic [BUS_W-1:0] func_data,
    input logic             func_oe,
    input logic [BUS_W-1:0] bus_data,
    input logic             bus_oe,
    input logic             tdo_oe
);

    logic [2:0] ones_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ones_run <= 3'd0;
        end else if (!tms) begin
            ones_run <= 3'd0;
        end else if (ones_run != 3'd5) begin
            ones_run <= ones_run + 3'd1;
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == TS_IDLE && !tms) |=> (tap_state == TS_IDLE)); // R1
    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run == 3'd5) |-> (tap_state == TS_RESET)); // R2
    AST_RESET_LOADS_BYPASS: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == TS_RESET) |=> (ir_cur == '1)); // R3
    AST_FUNC_PATH: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_cur != '0) |-> (bus_oe == func_oe && bus_data == func_data)); // R8
    AST_RESERVED_NO_TAKEOVER: assert property (@(posedge tck) disable iff (!trst_n)
        (bus_oe != func_oe) |-> (ir_cur == '0)); // R4
    AST_PRELOAD_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state != TS_DR_UPD && tap_state != TS_RESET) |=> $stable(upd_oe)); // R6
    AST_EXTEST_OE: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_cur == '0) |-> (bus_oe == upd_oe)); // R7
    AST_RESET_PRESETS_OE: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == TS_RESET) |=> upd_oe); // R9
    AST_TDO_OE_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (tap_state == TS_DR_SHIFT || tap_state == TS_IR_SHIFT)); // R11

endmodule

bind bscan_bus_ctl bscan_bus_ctl_chk #(.BUS_W(BUS_W), .IR_W(IR_W)) chk_i (
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .tap_state (tap_state),
    .ir_cur    (ir_cur),
    .upd_oe    (upd_oe),
    .func_data (func_data),
    .func_oe   (func_oe),
    .bus_data  (bus_data),
    .bus_oe    (bus_oe),
    .tdo_oe    (tdo_oe)
);

// File: tb/bscan_bus_ctl_tb.sv
`timescale 1ns/1ps
module bscan_bus_ctl_tb_top;

    localparam int BW = 8;
    localparam int IW = 3;

    typedef struct packed {
        logic [IW-1:0] ir;
        logic [BW:0]   din;
        logic [BW-1:0] fd;
        logic          foe;
        logic [BW-1:0] exp_bd;
        logic          exp_oe;
        logic [BW:0]   exp_out;
    } vec_t;

    // codes: 000 external test, 001 sample/preload, 111 bypass, others reserved
    localparam vec_t VECS [6] = '{
        '{3'b000, 9'h1A5, 8'h3C, 1'b0, 8'hA5, 1'b1, 9'h03C},
        '{3'b000, 9'h05A, 8'hC3, 1'b1, 8'h5A, 1'b0, 9'h1C3},
        '{3'b001, 9'h0FF, 8'h11, 1'b1, 8'h11, 1'b1, 9'h111},
        '{3'b111, 9'h100, 8'h22, 1'b0, 8'h22, 1'b0, 9'h000},
        '{3'b010, 9'h1F0, 8'h44, 1'b1, 8'h44, 1'b1, 9'h1E0},
        '{3'b101, 9'h155, 8'h66, 1'b0, 8'h66, 1'b0, 9'h0AA}
    };

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [BW-1:0] func_data = '0;
    logic          func_oe = 1'b0;
    logic          tdo;
    logic          tdo_oe;
    logic [BW-1:0] bus_data;
    logic          bus_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 tck = ~tck;

    bscan_bus_ctl #(.BUS_W(BW), .IR_W(IW)) dut_i (
        .tck       (tck),
        .trst_n    (trst_n),
        .tms       (tms),
        .tdi       (tdi),
        .func_data (func_data),
        .func_oe   (func_oe),
        .tdo       (tdo),
        .tdo_oe    (tdo_oe),
        .bus_data  (bus_data),
        .bus_oe    (bus_oe)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck);
        #1;
        o   = tdo;
        tms = m;
        tdi = d;
        @(posedge tck);
    endtask

    task automatic go(input logic m);
        logic o;
        step(m, 1'b0, o);
    endtask

    task automatic tap_reset();
        for (int i = 0; i < 5; i++) go(1'b1);
        go(1'b0);
    endtask

    task automatic load_ir(input logic [IW-1:0] code, output logic [IW-1:0] cap);
        logic o;
        go(1'b1); go(1'b1); go(1'b0); go(1'b0);
        for (int i = 0; i < IW; i++) begin
            step(i == IW-1, code[i], o);
            cap[i] = o;
        end
        go(1'b1); go(1'b0);
    endtask

    task automatic scan_dr(input logic [BW:0] din, output logic [BW:0] dout);
        logic o;
        go(1'b1); go(1'b0); go(1'b0);
        for (int i = 0; i <= BW; i++) begin
            step(i == BW, din[i], o);
            dout[i] = o;
        end
        go(1'b1); go(1'b0);
    endtask

    task automatic settle();
        @(negedge tck);
        #1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [IW-1:0] cap;
        logic [BW:0]   dout;

        // reset state, checked while trst_n is held low
        func_data = 8'h9E;
        func_oe   = 1'b1;
        #12;
        chk("R11 tdo_oe in reset", 16'(tdo_oe), 16'h0);
        chk("R8 bus_data in reset", 16'(bus_data), 16'h9E);
        chk("R8 bus_oe in reset", 16'(bus_oe), 16'h1);
        trst_n = 1'b1;
        tap_reset();

        // vector table
        foreach (VECS[k]) begin
            func_data = VECS[k].fd;
            func_oe   = VECS[k].foe;
            load_ir(VECS[k].ir, cap);
            chk("R1 R3 IR capture pattern", 16'(cap), 16'h1);
            scan_dr(VECS[k].din, dout);
            chk("R5 R10 scanned-out chain", 16'(dout), 16'(VECS[k].exp_out));
            settle();
            chk("R7 R8 bus_data", 16'(bus_data), 16'(VECS[k].exp_bd));
            chk("R7 R8 bus_oe", 16'(bus_oe), 16'(VECS[k].exp_oe));
            chk("R11 tdo_oe idle", 16'(tdo_oe), 16'h0);
        end

        // R6 R4: preload from the sample step survives bypass and reserved scans
        func_data = 8'h77;
        func_oe   = 1'b1;
        load_ir(3'b000, cap);
        settle();
        chk("R6 R4 preload data kept", 16'(bus_data), 16'hFF);
        chk("R6 R4 preload oe kept (floats bus)", 16'(bus_oe), 16'h0);

        // R9: passing through Reset presets the control cell
        tap_reset();
        settle();
        chk("R3 R8 bypass after reset", 16'(bus_data), 16'h77);
        load_ir(3'b000, cap);
        settle();
        chk("R9 oe preset after reset", 16'(bus_oe), 16'h1);
        chk("R9 data cleared after reset", 16'(bus_data), 16'h00);

        // R11: tdo_oe rises inside the shift state
        go(1'b1); go(1'b0); go(1'b0);
        settle();
        chk("R11 tdo_oe in shift", 16'(tdo_oe), 16'h1);
        tap_reset();

        // R2: asynchronous reset returns the bus to functional control
        load_ir(3'b000, cap);
        scan_dr(9'h0AA, dout);
        settle();
        chk("R7 extest floats bus", 16'(bus_oe), 16'h0);
        trst_n = 1'b0;
        #1;
        chk("R2 trst_n async bus_oe", 16'(bus_oe), 16'h1);
        chk("R2 trst_n async bus_data", 16'(bus_data), 16'h77);
        trst_n = 1'b1;
        go(1'b0);

        // R2: five ones from DR-Pause reach Reset
        load_ir(3'b000, cap);
        scan_dr(9'h055, dout);
        go(1'b1); go(1'b0); go(1'b0); go(1'b1); go(1'b0);
        settle();
        chk("R7 extest data before escape", 16'(bus_data), 16'h55);
        for (int i = 0; i < 5; i++) go(1'b1);
        go(1'b0);
        settle();
        chk("R2 five ones reach reset", 16'(bus_oe), 16'h1);
        chk("R2 five ones bus_data", 16'(bus_data), 16'h77);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule